// File: doc/BRIEF.md
# Variable-Length Instruction Field Splitter

The block takes a byte stream of variable-length instructions, one byte per cycle under a valid/ready handshake, and cuts each instruction into its parts. Each instruction has one or two opcode bytes. An addressing byte, an index byte, a displacement and an immediate may follow. The addressing byte decides whether the index byte is present and how wide the displacement is. A small per-opcode class input, presented alongside the final opcode byte, states whether an addressing byte follows and how many immediate bytes close the instruction.

For each instruction the block emits a record, valid for a single cycle. The record holds the opcode, the split subfields of the addressing and index bytes, the displacement and immediate values widened to 32 bits, their byte counts, and the instruction length. The block does not decode the opcode table, fetch operands or execute anything. Its consumer is a later decode stage, which reads the record in the cycle its valid flag is high.

Top module: `instr_field_parser`

## Requirements
- R1: A first byte of 0x0F marks a two-byte opcode. The byte after it is the final opcode and is reported with `out_two_byte_o`=1, even if it is 0x0F itself. Any other first byte is the final opcode, with `out_two_byte_o`=0.
- R2: The class inputs are sampled only with the final opcode byte and are ignored on every other byte. `cls_modrm_i`=1 means an addressing byte follows. `cls_imm_code_i` encodes the immediate size: 00 = none, 01 = 1 byte, 10 = 2 bytes, 11 = 4 bytes.
- R3: The addressing byte is split into mode (bits 7:6), reg (bits 5:3) and r/m (bits 2:0). All three read zero when there is no addressing byte.
- R4: An index byte follows the addressing byte exactly when mode is not 11 and r/m is 100. It is split into scale (7:6), index (5:3) and base (2:0), and these read zero when the index byte is absent.
- R5: The displacement byte count follows the mode field. Mode 01 gives 1 byte and mode 10 gives 4 bytes. Mode 11 gives none. Mode 00 gives none, except that it gives 4 bytes when r/m is 101, or, if an index byte is present, when its base is 101.
- R6: Displacement bytes are assembled least significant first and sign-extended to 32 bits. The value is zero when the displacement is absent.
- R7: Immediate bytes follow the displacement, are assembled least significant first, and end the instruction.
- R8: The immediate is sign-extended from its own width when `cls_sext_i` was 1 with the final opcode byte and bit 1 of that opcode is 1. Otherwise it is zero-extended.
- R9: `out_len_o` equals the number of bytes in the instruction, from 1 to 12.
- R10: `out_valid_o` is high for exactly the one cycle after the last byte of an instruction is accepted. The record fields keep their values until the next record is emitted.
- R11: `in_ready_o` is high from the first clock after reset onward. The first byte of the next instruction is accepted in the same cycle that the previous record is valid, with no byte lost. A byte offered with `in_valid_i`=0 has no effect.
- R12: During reset, `out_valid_o` and `in_ready_o` are 0, and the parser starts at an opcode byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input byte valid |
| in_byte_i | input | 8 | Instruction byte |
| in_ready_o | output | 1 | Parser accepts a byte |
| cls_modrm_i | input | 1 | Final opcode has an addressing byte |
| cls_imm_code_i | input | 2 | Immediate size code of the final opcode |
| cls_sext_i | input | 1 | Final opcode carries a sign-extend bit at bit 1 |
| out_valid_o | output | 1 | Record valid pulse |
| out_two_byte_o | output | 1 | Opcode was escaped with 0x0F |
| out_opc_o | output | 8 | Final opcode byte |
| out_has_modrm_o | output | 1 | Addressing byte present |
| out_mod_o | output | 2 | Mode field |
| out_reg_o | output | 3 | Reg field |
| out_rm_o | output | 3 | R/m field |
| out_has_sib_o | output | 1 | Index byte present |
| out_ss_o | output | 2 | Scale field |
| out_index_o | output | 3 | Index field |
| out_base_o | output | 3 | Base field |
| out_disp_bytes_o | output | 3 | Displacement byte count |
| out_disp_o | output | 32 | Sign-extended displacement |
| out_imm_bytes_o | output | 3 | Immediate byte count |
| out_imm_o | output | 32 | Extended immediate |
| out_len_o | output | 4 | Instruction length in bytes |

## Verification
The two events that coincide are the emission of one instruction's record and the acceptance of the next instruction's first byte. With a gap-free stream they fall in the same cycle every time an instruction ends. Runs of one-byte opcodes go further and produce a valid record on consecutive cycles. The bench first feeds directed instructions back to back with no bubbles, then a random stream with random idle cycles. A behavioural model predicts, for every cycle, whether a record is due and what it holds. A dropped or merged byte therefore shows up as a wrong length or wrong fields in the record that follows.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
  localparam int unsigned FIELD_W = 32;
  localparam int unsigned LEN_W   = 4;
  localparam int unsigned CNT_W   = 3;

  typedef enum logic [2:0] {
    S_OPC, S_OPC2, S_MODRM, S_SIB, S_DISP, S_IMM
  } state_e;

  typedef struct packed {
    logic               two_byte;
    logic [7:0]         opc;
    logic               has_modrm;
    logic [7:0]         modrm;
    logic               has_sib;
    logic [7:0]         sib;
    logic [CNT_W-1:0]   disp_n;
    logic [FIELD_W-1:0] disp_raw;
    logic [CNT_W-1:0]   imm_n;
    logic [FIELD_W-1:0] imm_raw;
    logic               imm_sext;
    logic [LEN_W-1:0]   len;
  } rec_t;

  function automatic logic [CNT_W-1:0] imm_code_bytes(input logic [1:0] code);
    case (code)
      2'd1:    return CNT_W'(1);
      2'd2:    return CNT_W'(2);
      2'd3:    return CNT_W'(4);
      default: return '0;
    endcase
  endfunction

  // first pending field wins; S_OPC means the instruction is complete
  function automatic state_e pick_next(input logic need_modrm, input logic need_sib,
                                       input logic [CNT_W-1:0] dn, input logic [CNT_W-1:0] in);
    if (need_modrm)   return S_MODRM;
    if (need_sib)     return S_SIB;
    if (dn != '0)     return S_DISP;
    if (in != '0)     return S_IMM;
    return S_OPC;
  endfunction
endpackage

// File: rtl/ifp_mode_dec.sv
module ifp_mode_dec
  import ifp_pkg::*;
(
  input  logic [1:0]       mod_i,
  input  logic [2:0]       low3_i,     // r/m, or base in the index phase
  input  logic             sib_phase_i,
  output logic             need_sib_o,
  output logic [CNT_W-1:0] disp_n_o
);
  always_comb begin
    need_sib_o = !sib_phase_i && (mod_i != 2'b11) && (low3_i == 3'b100);
    unique case (mod_i)
      2'b01:   disp_n_o = CNT_W'(1);
      2'b10:   disp_n_o = CNT_W'(4);
      2'b00:   disp_n_o = (low3_i == 3'b101) ? CNT_W'(4) : '0;
      default: disp_n_o = '0;
    endcase
  end
endmodule

// File: rtl/ifp_field_ext.sv
module ifp_field_ext
  import ifp_pkg::*;
(
  input  logic [FIELD_W-1:0] raw_i,
  input  logic [CNT_W-1:0]   nbytes_i,
  input  logic               sext_i,
  output logic [FIELD_W-1:0] val_o
);
  always_comb begin
    unique case (nbytes_i)
      CNT_W'(1): val_o = {{(FIELD_W-8){sext_i & raw_i[7]}}, raw_i[7:0]};
      CNT_W'(2): val_o = {{(FIELD_W-16){sext_i & raw_i[15]}}, raw_i[15:0]};
      CNT_W'(4): val_o = raw_i;
      default:   val_o = '0;
    endcase
  end
endmodule

// File: rtl/instr_field_parser.sv
module instr_field_parser
  import ifp_pkg::*;
#(
  parameter logic [7:0]  ESC_OPC  = 8'h0F,
  parameter int unsigned SEXT_BIT = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [7:0]         in_byte_i,
  output logic               in_ready_o,
  input  logic               cls_modrm_i,
  input  logic [1:0]         cls_imm_code_i,
  input  logic               cls_sext_i,
  output logic               out_valid_o,
  output logic               out_two_byte_o,
  output logic [7:0]         out_opc_o,
  output logic               out_has_modrm_o,
  output logic [1:0]         out_mod_o,
  output logic [2:0]         out_reg_o,
  output logic [2:0]         out_rm_o,
  output logic               out_has_sib_o,
  output logic [1:0]         out_ss_o,
  output logic [2:0]         out_index_o,
  output logic [2:0]         out_base_o,
  output logic [2:0]         out_disp_bytes_o,
  output logic [31:0]        out_disp_o,
  output logic [2:0]         out_imm_bytes_o,
  output logic [31:0]        out_imm_o,
  output logic [3:0]         out_len_o
);
  localparam int unsigned MAX_LEN = 12;

  state_e           st_q, st_d;
  rec_t             wk_q, wk_d, rec_q;
  logic [1:0]       cnt_q, cnt_d;
  logic             rdy_q, vld_q;
  logic             acc, fin_opc, done;
  logic             dec_sib;
  logic [CNT_W-1:0] dec_dn;
  logic [1:0]       dec_mod;

  assign acc     = in_valid_i & rdy_q;
  assign dec_mod = (st_q == S_SIB) ? wk_q.modrm[7:6] : in_byte_i[7:6];

  ifp_mode_dec u_mode_dec (
    .mod_i       (dec_mod),
    .low3_i      (in_byte_i[2:0]),
    .sib_phase_i (st_q == S_SIB),
    .need_sib_o  (dec_sib),
    .disp_n_o    (dec_dn)
  );

  always_comb begin
    wk_d    = wk_q;
    st_d    = st_q;
    cnt_d   = cnt_q;
    fin_opc = 1'b0;
    if (acc) begin
      if (st_q == S_OPC) begin
        wk_d     = '0;
        wk_d.len = LEN_W'(1);
      end else begin
        wk_d.len = wk_q.len + 1'b1;
      end
      unique case (st_q)
        S_OPC: begin
          wk_d.opc = in_byte_i;
          if (in_byte_i == ESC_OPC) begin
            wk_d.two_byte = 1'b1;
            st_d          = S_OPC2;
          end else begin
            fin_opc = 1'b1;
          end
        end
        S_OPC2: begin
          wk_d.opc = in_byte_i;
          fin_opc  = 1'b1;
        end
        S_MODRM: begin
          wk_d.modrm   = in_byte_i;
          wk_d.has_sib = dec_sib;
          wk_d.disp_n  = dec_sib ? '0 : dec_dn;
          st_d = pick_next(1'b0, dec_sib, wk_d.disp_n, wk_q.imm_n);
        end
        S_SIB: begin
          wk_d.sib    = in_byte_i;
          wk_d.disp_n = dec_dn;
          st_d = pick_next(1'b0, 1'b0, dec_dn, wk_q.imm_n);
        end
        S_DISP: begin
          wk_d.disp_raw[{cnt_q, 3'b000} +: 8] = in_byte_i;
          if ({1'b0, cnt_q} == wk_q.disp_n - 1'b1) begin
            cnt_d = '0;
            st_d  = pick_next(1'b0, 1'b0, '0, wk_q.imm_n);
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_IMM: begin
          wk_d.imm_raw[{cnt_q, 3'b000} +: 8] = in_byte_i;
          if ({1'b0, cnt_q} == wk_q.imm_n - 1'b1) begin
            cnt_d = '0;
            st_d  = S_OPC;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = S_OPC;
      endcase
      if (fin_opc) begin
        wk_d.has_modrm = cls_modrm_i;
        wk_d.imm_n     = imm_code_bytes(cls_imm_code_i);
        wk_d.imm_sext  = cls_sext_i & in_byte_i[SEXT_BIT];
        st_d = pick_next(cls_modrm_i, 1'b0, '0, wk_d.imm_n);
      end
    end
  end

  assign done = acc && (st_d == S_OPC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_OPC;
      wk_q  <= '0;
      rec_q <= '0;
      cnt_q <= '0;
      rdy_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      wk_q  <= wk_d;
      cnt_q <= cnt_d;
      rdy_q <= 1'b1;
      vld_q <= done;
      if (done) rec_q <= wk_d;
    end
  end

  ifp_field_ext u_disp_ext (
    .raw_i    (rec_q.disp_raw),
    .nbytes_i (rec_q.disp_n),
    .sext_i   (1'b1),
    .val_o    (out_disp_o)
  );

  ifp_field_ext u_imm_ext (
    .raw_i    (rec_q.imm_raw),
    .nbytes_i (rec_q.imm_n),
    .sext_i   (rec_q.imm_sext),
    .val_o    (out_imm_o)
  );

  assign in_ready_o       = rdy_q;
  assign out_valid_o      = vld_q;
  assign out_two_byte_o   = rec_q.two_byte;
  assign out_opc_o        = rec_q.opc;
  assign out_has_modrm_o  = rec_q.has_modrm;
  assign out_mod_o        = rec_q.modrm[7:6];
  assign out_reg_o        = rec_q.modrm[5:3];
  assign out_rm_o         = rec_q.modrm[2:0];
  assign out_has_sib_o    = rec_q.has_sib;
  assign out_ss_o         = rec_q.sib[7:6];
  assign out_index_o      = rec_q.sib[5:3];
  assign out_base_o       = rec_q.sib[2:0];
  assign out_disp_bytes_o = rec_q.disp_n;
  assign out_imm_bytes_o  = rec_q.imm_n;
  assign out_len_o        = rec_q.len;

  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> $past(acc)); // R10
  AST_SIB_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (rec_q.has_sib == (rec_q.has_modrm && rec_q.modrm[7:6] != 2'b11
                                 && rec_q.modrm[2:0] == 3'b100))); // R4
  AST_DISP_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (rec_q.disp_n == 3'd0 || rec_q.disp_n == 3'd1 || rec_q.disp_n == 3'd4)); // R5
  AST_DISP_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_DISP) |-> ({1'b0, cnt_q} < wk_q.disp_n)); // R5
  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (rec_q.len != '0 && rec_q.len <= LEN_W'(MAX_LEN))); // R9
  AST_BACK_TO_OPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (st_q == S_OPC)); // R11
endmodule

// File: tb/sim_instr_field_parser.sv
module sim_instr_field_parser;
  typedef struct packed {
    logic        two_byte;
    logic [7:0]  opc;
    logic        hm;
    logic [7:0]  modrm;
    logic        hs;
    logic [7:0]  sib;
    logic [2:0]  dn;
    logic [31:0] disp;
    logic [2:0]  in;
    logic [31:0] imm;
    logic        sx;
    logic [3:0]  len;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic cls_modrm = 1'b0;
  logic [1:0] cls_code = 2'b00;
  logic cls_sext = 1'b0;
  logic in_ready, out_valid, out_two_byte, out_has_modrm, out_has_sib;
  logic [7:0] out_opc;
  logic [1:0] out_mod, out_ss;
  logic [2:0] out_reg, out_rm, out_index, out_base, out_disp_bytes, out_imm_bytes;
  logic [31:0] out_disp, out_imm;
  logic [3:0] out_len;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  logic [7:0] bq[$];
  logic       lq[$];
  logic [3:0] cq[$];
  exp_t       eq[$];
  exp_t       last_e;
  bit         have_last = 0;
  bit         gap_en = 0;

  always #4 clk = ~clk;

  instr_field_parser u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_byte_i(in_byte),
    .in_ready_o(in_ready), .cls_modrm_i(cls_modrm), .cls_imm_code_i(cls_code),
    .cls_sext_i(cls_sext), .out_valid_o(out_valid), .out_two_byte_o(out_two_byte),
    .out_opc_o(out_opc), .out_has_modrm_o(out_has_modrm), .out_mod_o(out_mod),
    .out_reg_o(out_reg), .out_rm_o(out_rm), .out_has_sib_o(out_has_sib),
    .out_ss_o(out_ss), .out_index_o(out_index), .out_base_o(out_base),
    .out_disp_bytes_o(out_disp_bytes), .out_disp_o(out_disp),
    .out_imm_bytes_o(out_imm_bytes), .out_imm_o(out_imm), .out_len_o(out_len)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s act=%h exp=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ext(input logic [31:0] v, input int n, input bit s);
    logic [31:0] r;
    case (n)
      1: r = {{24{s & v[7]}}, v[7:0]};
      2: r = {{16{s & v[15]}}, v[15:0]};
      4: r = v;
      default: r = 32'h0;
    endcase
    return r;
  endfunction

  task automatic push(input logic [7:0] b, input bit last, input logic [3:0] cls);
    bq.push_back(b); lq.push_back(last); cq.push_back(cls);
  endtask

  // builds the byte stream and the expected record of one instruction
  task automatic add_instr(input bit esc, input logic [7:0] op, input bit hm,
                           input logic [7:0] modrm, input logic [7:0] sib,
                           input logic [31:0] dispv, input logic [1:0] icode,
                           input bit sx, input logic [31:0] immv);
    exp_t e;
    int dn, inn, tot, k;
    bit hs;
    logic [2:0] lo;
    hs  = hm && modrm[7:6] != 2'b11 && modrm[2:0] == 3'd4;
    lo  = hs ? sib[2:0] : modrm[2:0];
    dn  = !hm ? 0 : (modrm[7:6] == 2'd1) ? 1 : (modrm[7:6] == 2'd2) ? 4 :
          (modrm[7:6] == 2'd0 && lo == 3'd5) ? 4 : 0;
    inn = (icode == 2'd3) ? 4 : int'(icode);
    tot = (esc ? 2 : 1) + (hm ? 1 : 0) + (hs ? 1 : 0) + dn + inn;
    k = 0;
    if (esc) begin k++; push(8'h0F, k == tot, 4'($urandom)); end
    k++; push(op, k == tot, {hm, icode, sx});
    if (hm) begin k++; push(modrm, k == tot, 4'($urandom)); end
    if (hs) begin k++; push(sib, k == tot, 4'($urandom)); end
    for (int i = 0; i < dn; i++) begin k++; push(dispv[8*i +: 8], k == tot, 4'($urandom)); end
    for (int i = 0; i < inn; i++) begin k++; push(immv[8*i +: 8], k == tot, 4'($urandom)); end
    e.two_byte = esc; e.opc = op; e.hm = hm;
    e.modrm = hm ? modrm : 8'h00; e.hs = hs; e.sib = hs ? sib : 8'h00;
    e.dn = 3'(dn); e.disp = ext(dispv, dn, 1'b1);
    e.in = 3'(inn); e.sx = sx && op[1]; e.imm = ext(immv, inn, sx && op[1]);
    e.len = 4'(tot);
    eq.push_back(e);
  endtask

  task automatic cmp(input exp_t e, input bit v);
    chk("R10", "valid", 32'(out_valid), 32'(v));
    if (!have_last && !v) return;
    chk("R1", "two_byte", 32'(out_two_byte), 32'(e.two_byte));
    chk("R1", "opcode", 32'(out_opc), 32'(e.opc));
    chk("R2", "has_modrm", 32'(out_has_modrm), 32'(e.hm));
    chk("R3", "mod/reg/rm", {24'h0, out_mod, out_reg, out_rm}, {24'h0, e.modrm});
    chk("R4", "has_sib", 32'(out_has_sib), 32'(e.hs));
    chk("R4", "ss/index/base", {24'h0, out_ss, out_index, out_base}, {24'h0, e.sib});
    chk("R5", "disp_bytes", 32'(out_disp_bytes), 32'(e.dn));
    chk("R6", "disp", out_disp, e.disp);
    chk("R2", "imm_bytes", 32'(out_imm_bytes), 32'(e.in));
    if (e.sx) chk("R8", "imm sext", out_imm, e.imm);
    else      chk("R7", "imm", out_imm, e.imm);
    chk("R9", "len", 32'(out_len), 32'(e.len));
  endtask

  // checks the previous edge's result, then drives the next byte
  task automatic run_stream();
    bit pend = 0;
    exp_t e;
    while (bq.size() > 0 || pend) begin
      @(negedge clk);
      if (pend) begin
        e = eq.pop_front();
        cmp(e, 1'b1);
        last_e = e; have_last = 1;
      end else begin
        cmp(last_e, 1'b0);
      end
      if (bq.size() > 0 && (!gap_en || ($urandom % 3) != 0)) begin
        chk("R11", "ready", 32'(in_ready), 32'd1);
        in_valid = 1'b1;
        in_byte = bq.pop_front();
        {cls_modrm, cls_code, cls_sext} = cq.pop_front();
        pend = lq.pop_front();
      end else begin
        in_valid = 1'b0;
        in_byte = 8'($urandom);
        {cls_modrm, cls_code, cls_sext} = 4'($urandom);
        pend = 0;
      end
    end
    @(negedge clk);
    cmp(last_e, 1'b0);
  endtask

  initial begin
    // R12: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R12", "valid in reset", 32'(out_valid), 32'd0);
      chk("R12", "ready in reset", 32'(in_ready), 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "ready after reset", 32'(in_ready), 32'd1);
    chk("R12", "valid after reset", 32'(out_valid), 32'd0);

    // directed, back to back: record pulse coincides with next first byte
    add_instr(0, 8'h90, 0, 0, 0, 0, 2'd0, 0, 0);                               // R1 one byte
    add_instr(0, 8'h90, 0, 0, 0, 0, 2'd0, 0, 0);                               // R10 consecutive pulses
    add_instr(1, 8'h05, 0, 0, 0, 0, 2'd0, 0, 0);                               // R1 escaped
    add_instr(1, 8'h0F, 0, 0, 0, 0, 2'd0, 0, 0);                               // R1 0F 0F
    add_instr(0, 8'h01, 1, 8'hC3, 0, 0, 2'd0, 0, 0);                           // R3 register mode
    add_instr(0, 8'h8B, 1, 8'h45, 0, 32'h000000F0, 2'd0, 0, 0);                // R5 R6 disp8 negative
    add_instr(0, 8'h8B, 1, 8'h05, 0, 32'h12345678, 2'd0, 0, 0);                // R5 mod00 rm101
    add_instr(0, 8'h8B, 1, 8'h04, 8'h25, 32'h9ABCDEF0, 2'd0, 0, 0);            // R4 R5 base101
    add_instr(0, 8'h8B, 1, 8'h04, 8'h88, 0, 2'd0, 0, 0);                       // R4 no disp
    add_instr(0, 8'h8B, 1, 8'h84, 8'hC8, 32'h80000001, 2'd0, 0, 0);            // R4 mod10
    add_instr(0, 8'h8B, 1, 8'h44, 8'h4B, 32'h0000007F, 2'd0, 0, 0);            // R4 mod01
    add_instr(0, 8'h8B, 1, 8'hC4, 0, 0, 2'd0, 0, 0);                           // R4 mod11 rm100 no index
    add_instr(0, 8'h83, 1, 8'hC0, 0, 0, 2'd1, 1, 32'h00000080);                // R8 sext imm8
    add_instr(0, 8'h80, 1, 8'hC0, 0, 0, 2'd1, 1, 32'h00000080);                // R8 bit1 clear
    add_instr(0, 8'h6B, 0, 0, 0, 0, 2'd2, 0, 32'h00008234);                    // R7 imm16 zero-ext
    add_instr(0, 8'h6B, 0, 0, 0, 0, 2'd2, 1, 32'h00008234);                    // R8 imm16 sext
    add_instr(0, 8'h68, 0, 0, 0, 0, 2'd3, 0, 32'hCAFEF00D);                    // R7 imm32
    add_instr(1, 8'hBA, 1, 8'h84, 8'h25, 32'h11223344, 2'd3, 0, 32'h55667788); // R9 length 12
    add_instr(0, 8'h90, 0, 0, 0, 0, 2'd0, 0, 0);
    gap_en = 0;
    run_stream();

    // random stream with idle cycles and junk on unused inputs
    for (int n = 0; n < 400; n++) begin
      logic [7:0] op;
      bit esc;
      esc = ($urandom % 4) == 0;
      op = 8'($urandom);
      if (!esc && op == 8'h0F) op = 8'h0E;
      add_instr(esc, op, 1'($urandom), 8'($urandom), 8'($urandom), $urandom,
                2'($urandom), 1'($urandom), $urandom);
    end
    gap_en = 1;
    run_stream();

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule